// File: doc/BRIEF.md
# TMDS Source Period Scheduler

This block sits in the pixel clock domain of a display link transmitter. On every cycle it decides what the three TMDS data channels carry: control bits, packet nibbles, video bytes or a guard band. It passes a 2-bit period code and an 8-bit payload per channel to the character encoders downstream. The period decision uses the timing inputs and a link mode. A timing generator supplies data enable, the syncs, and a count of the blanking cycles left before the next active video. A packet source raises a request and supplies one nibble per channel. It is told on each cycle whether its nibble was used.

The link mode always starts in legacy DVI mode, and a new-sink strobe returns it there. It moves to enhanced HDMI mode only after a sink-capability strobe. In DVI mode the block sends no guard bands and no data islands. It also forces the pixel format to RGB and flags any other request as an error. In HDMI mode two guard-band cycles come before each video period. Each data island is a fixed run of packet cycles with two guard-band cycles on each side. An island is placed only when the remaining blanking can hold the whole island and the video leading guard band.

Top module: `tmds_period_sched`

## Requirements
- R1: After reset, and in the cycle after `sink_new` is high, `hdmi_mode` is 0. `sink_new` wins over `sink_hdmi` when both are high in the same cycle.
- R2: A cycle with `sink_hdmi` high and `sink_new` low sets `hdmi_mode` to 1 from the next cycle on.
- R3: Each output is registered and reflects the inputs of the previous cycle. The same 2-bit code goes to all channels: 00 control, 01 packet, 10 video, 11 guard band, with channel n at `ptype[2n+1:2n]`. A cycle with `de` high gives code 10, and the payload of channel n is `vid[8n+7:8n]`.
- R4: In a control period, channel 0 payload bit 0 is hsync, bit 1 is vsync, and its other bits are 0. Channels 1 and 2 carry all zeros.
- R5: In DVI mode no guard-band code (11) is ever produced.
- R6: In DVI mode `pkt_req` has no effect: no packet code is produced and `pkt_take` stays 0.
- R7: In DVI mode, `fmt_out` is 00 (RGB). `fmt_err` is 1 when `fmt_req` is not 00. In HDMI mode `fmt_req` passes through to `fmt_out` and `fmt_err` is 0.
- R8: In HDMI mode, blanking cycles with `cyc_to_de` equal to 2 or 1 produce the guard-band code, with all-zero payloads.
- R9: In HDMI mode, when no island is running, a blanking cycle with `pkt_req` high and `cyc_to_de` >= PKT_CYC+6 starts an island. The island is 2 guard-band cycles, then PKT_CYC packet cycles, then 2 guard-band cycles. During the packet input cycles `pkt_take` is 1, and the payload of channel n is `{4'b0, nib[4n+3:4n]}`.
- R10: A packet request while `cyc_to_de` < PKT_CYC+6 is not honoured, and that cycle gives control or the leading guard band.
- R11: A `sink_new` strobe during an island aborts it. From the second output after the strobe on, no guard-band or packet code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sink_new | input | 1 | New sink detected; forces DVI mode |
| sink_hdmi | input | 1 | Sink identified as HDMI-capable |
| de | input | 1 | Active video |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| cyc_to_de | input | CW | Blanking cycles left before `de` rises (0 while `de` is high) |
| vid | input | 3*PIXW | Pixel bytes, channel 0 in the low byte |
| fmt_req | input | 2 | Requested pixel format, 00 = RGB |
| pkt_req | input | 1 | Packet data waiting |
| nib | input | 3*NIBW | Packet nibble per channel |
| pkt_take | output | 1 | Nibble on `nib` is used this cycle |
| hdmi_mode | output | 1 | 1 = enhanced mode, 0 = DVI mode |
| ptype | output | 6 | Period code per channel |
| payload | output | 3*PIXW | Payload per channel |
| fmt_out | output | 2 | Pixel format in effect |
| fmt_err | output | 1 | Non-RGB request refused in DVI mode |

## Verification
The embedded assertions check on every cycle that DVI mode never yields a guard-band or packet code and that a new-sink strobe always drops the mode. They also check format forcing and error flagging, leading guard bands at the two cycles before video, packet codes after every nibble take, guard-band entry into each packet run, and zero payloads on the idle channels. Island length and placement, refusal of late requests, abort on sink change, and the exact payload bytes only show up in the bench's frame-timed scenarios. There a reference model follows every cycle through random traffic and the directed corner cases.

// File: rtl/tmds_period_sched.sv
module tmds_period_sched #(
  parameter int PIXW    = 8,
  parameter int NIBW    = 4,
  parameter int CW      = 12,
  parameter int PKT_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sink_new,
  input  logic              sink_hdmi,
  input  logic              de,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [CW-1:0]     cyc_to_de,
  input  logic [3*PIXW-1:0] vid,
  input  logic [1:0]        fmt_req,
  input  logic              pkt_req,
  input  logic [3*NIBW-1:0] nib,
  output logic              pkt_take,
  output logic              hdmi_mode,
  output logic [5:0]        ptype,
  output logic [3*PIXW-1:0] payload,
  output logic [1:0]        fmt_out,
  output logic              fmt_err
);
  localparam int NCH    = 3;
  localparam int LAST   = PKT_CYC + 4;
  localparam int PW     = $clog2(LAST + 1);
  localparam int MINGAP = PKT_CYC + 6;
  localparam logic [1:0] K_CTL = 2'b00, K_PKT = 2'b01, K_VID = 2'b10, K_GB = 2'b11;

  logic          hdmi_q;
  logic [PW-1:0] pos_q, slot;
  logic [1:0]    kind;

  wire start   = hdmi_q && pkt_req && !de && (cyc_to_de >= CW'(MINGAP)) && (pos_q == '0);
  assign slot  = (pos_q != '0) ? pos_q : (start ? PW'(1) : '0);
  wire isl_gb  = (slot == PW'(1)) || (slot == PW'(2)) || (slot == PW'(LAST - 1)) || (slot == PW'(LAST));
  wire isl_pk  = (slot >= PW'(3)) && (slot <= PW'(PKT_CYC + 2));
  wire lead_gb = hdmi_q && !de && ((cyc_to_de == CW'(1)) || (cyc_to_de == CW'(2)));

  always_comb begin
    if (de)                     kind = K_VID;
    else if (isl_pk)            kind = K_PKT;
    else if (isl_gb || lead_gb) kind = K_GB;
    else                        kind = K_CTL;
  end

  assign pkt_take  = (pos_q >= PW'(3)) && (pos_q <= PW'(PKT_CYC + 2));
  assign hdmi_mode = hdmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdmi_q  <= 1'b0;
      pos_q   <= '0;
      ptype   <= '0;
      payload <= '0;
      fmt_out <= 2'b00;
      fmt_err <= 1'b0;
    end else begin
      if (sink_new)       hdmi_q <= 1'b0;
      else if (sink_hdmi) hdmi_q <= 1'b1;
      if (sink_new || slot == '0 || slot == PW'(LAST)) pos_q <= '0;
      else                                             pos_q <= slot + PW'(1);
      ptype   <= {NCH{kind}};
      fmt_out <= hdmi_q ? fmt_req : 2'b00;
      fmt_err <= !hdmi_q && (fmt_req != 2'b00);
      for (int ch = 0; ch < NCH; ch++) begin
        case (kind)
          K_VID:   payload[ch*PIXW +: PIXW] <= vid[ch*PIXW +: PIXW];
          K_PKT:   payload[ch*PIXW +: PIXW] <= PIXW'(nib[ch*NIBW +: NIBW]);
          K_CTL:   payload[ch*PIXW +: PIXW] <= (ch == 0) ? PIXW'({vsync, hsync}) : '0;
          default: payload[ch*PIXW +: PIXW] <= '0;
        endcase
      end
    end
  end

  a_r1_new_sink_dvi: assert property (@(posedge clk) disable iff (!rst_n)
    sink_new |=> !hdmi_mode);
  a_r5_dvi_no_gb: assert property (@(posedge clk) disable iff (!rst_n)
    !hdmi_mode |=> (ptype[1:0] != K_GB));
  a_r6_dvi_no_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    !hdmi_mode |=> (ptype[1:0] != K_PKT) && !pkt_take);
  a_r7_fmt_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdmi_mode && fmt_req != 2'b00) |=> fmt_err && (fmt_out == 2'b00));
  a_r8_lead_gb: assert property (@(posedge clk) disable iff (!rst_n)
    (hdmi_mode && !de && pos_q == '0 && (cyc_to_de == CW'(1) || cyc_to_de == CW'(2)))
      |=> (ptype[1:0] == K_GB) && (payload == '0));
  a_r9_take_is_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_take && !de) |=> (ptype[1:0] == K_PKT));
  a_r9_gb_before_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (ptype[1:0] == K_PKT && $past(ptype[1:0]) != K_PKT) |-> ($past(ptype[1:0]) == K_GB));
  a_r4_ctl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ptype[1:0] == K_CTL) |-> (payload[3*PIXW-1:PIXW] == '0) && (payload[PIXW-1:2] == '0));
endmodule

// File: tb/sim_tmds_period_sched.sv
module sim_tmds_period_sched;
  localparam int P    = 32;
  localparam int HT   = 120;
  localparam int ACT0 = 80;
  localparam int LAST = P + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sink_new = 0, sink_hdmi = 0, de = 0, hsync = 0, vsync = 0, pkt_req = 0;
  logic [11:0] cyc_to_de = 0;
  logic [23:0] vid = 0;
  logic [1:0]  fmt_req = 0;
  logic [11:0] nib = 0;
  logic        pkt_take, hdmi_mode, fmt_err;
  logic [5:0]  ptype;
  logic [23:0] payload;
  logic [1:0]  fmt_out;

  int n_chk = 0, n_bad = 0, hpos = 0, since_new = 99;
  bit m_hdmi = 0;
  int m_pos = 0;

  always #2 clk = ~clk;

  tmds_period_sched u0 (.clk(clk), .rst_n(rst_n), .sink_new(sink_new), .sink_hdmi(sink_hdmi),
    .de(de), .hsync(hsync), .vsync(vsync), .cyc_to_de(cyc_to_de), .vid(vid), .fmt_req(fmt_req),
    .pkt_req(pkt_req), .nib(nib), .pkt_take(pkt_take), .hdmi_mode(hdmi_mode), .ptype(ptype),
    .payload(payload), .fmt_out(fmt_out), .fmt_err(fmt_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot_of(input bit start);
    return (m_pos != 0) ? m_pos : (start ? 1 : 0);
  endfunction

  function automatic logic [1:0] kind_of(input int s);
    if (de) return 2'b10;
    if (s >= 3 && s <= P + 2) return 2'b01;
    if (s == 1 || s == 2 || s == LAST - 1 || s == LAST) return 2'b11;
    if (m_hdmi && (cyc_to_de == 1 || cyc_to_de == 2)) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [23:0] pay_of(input logic [1:0] k);
    case (k)
      2'b10:   return vid;
      2'b01:   return {4'b0, nib[11:8], 4'b0, nib[7:4], 4'b0, nib[3:0]};
      2'b00:   return {22'b0, vsync, hsync};
      default: return 24'b0;
    endcase
  endfunction

  task automatic set_timing();
    de = (hpos >= ACT0);
    cyc_to_de = de ? 12'd0 : 12'(ACT0 - hpos);
  endtask

  task automatic step(input bit rnd, input int p_hdmi, input int p_new);
    bit start;
    int s;
    logic [1:0] ek, eft;
    logic [23:0] ep;
    bit eerr, eh;
    string tag;
    set_timing();
    if (rnd) begin
      pkt_req   = ($urandom_range(0, 9) < 3);
      hsync     = 1'($urandom);
      vsync     = 1'($urandom);
      vid       = 24'($urandom);
      nib       = 12'($urandom);
      fmt_req   = 2'($urandom);
      sink_hdmi = (p_hdmi != 0) && ($urandom_range(0, p_hdmi - 1) == 0);
      sink_new  = (p_new != 0) && ($urandom_range(0, p_new - 1) == 0);
    end
    #0.5;
    chk(pkt_take == (m_pos >= 3 && m_pos <= P + 2), m_hdmi ? "R9" : "R6", 32'(pkt_take),
        32'(m_pos >= 3 && m_pos <= P + 2));
    start = m_hdmi && pkt_req && !de && cyc_to_de >= 12'(P + 6) && m_pos == 0;
    s  = slot_of(start);
    ek = kind_of(s);
    ep = pay_of(ek);
    eft  = m_hdmi ? fmt_req : 2'b00;
    eerr = !m_hdmi && fmt_req != 2'b00;
    eh   = sink_new ? 1'b0 : (sink_hdmi ? 1'b1 : m_hdmi);
    case (ek)
      2'b10: tag = "R3";
      2'b01: tag = "R9";
      2'b11: tag = (s != 0) ? "R9" : "R8";
      default: tag = !m_hdmi ? (pkt_req ? "R6" : "R5") :
                     ((pkt_req && !de && m_pos == 0) ? "R10" : "R4");
    endcase
    if (since_new < 3 && ek != 2'b10) tag = "R11";
    since_new = sink_new ? 0 : since_new + 1;
    @(posedge clk);
    m_pos  = (sink_new || s == 0 || s == LAST) ? 0 : s + 1;
    m_hdmi = eh;
    hpos   = (hpos + 1) % HT;
    @(negedge clk);
    chk(ptype == {3{ek}}, tag, 32'(ptype), 32'({3{ek}}));
    chk(payload == ep, (ek == 2'b00) ? "R4" : tag, 32'(payload), 32'(ep));
    chk(fmt_out == eft && fmt_err == eerr, "R7", {fmt_err, fmt_out}, {eerr, eft});
    chk(hdmi_mode == eh, eh ? "R2" : "R1", 32'(hdmi_mode), 32'(eh));
    sink_new = 0;
    sink_hdmi = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(hdmi_mode == 0 && ptype == 0 && payload == 0 && !fmt_err, "R1",
        {hdmi_mode, ptype, fmt_err}, 0);
    rst_n = 1;
    for (int i = 0; i < 1200; i++) step(1, 0, 0);
    sink_hdmi = 1;
    step(0, 0, 0);
    for (int i = 0; i < 2400; i++) step(1, 40, 300);
    // R10: request one cycle too late for an island
    hpos = 0; sink_hdmi = 1; step(0, 0, 0);
    hpos = ACT0 - (P + 5); pkt_req = 1; step(0, 0, 0);
    pkt_req = 0;
    while (hpos != 0) step(0, 0, 0);
    // R9 then R11: start an island, abort with a new sink
    sink_hdmi = 1; step(0, 0, 0);
    hpos = ACT0 - (P + 6); pkt_req = 1; nib = 12'ha5c; step(0, 0, 0);
    pkt_req = 0;
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    sink_new = 1; step(0, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    // R1: new sink wins over capability strobe in the same cycle
    sink_new = 1; sink_hdmi = 1; step(0, 0, 0);
    // R7: HDMI format pass-through
    sink_hdmi = 1; step(0, 0, 0);
    fmt_req = 2'b10; step(0, 0, 0);
    fmt_req = 2'b00;
    for (int i = 0; i < 500; i++) step(1, 60, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule